// File: doc/BRIEF.md
# Single-wire serial bus master

This block is a memory-mapped master for a single open-drain data line. Software writes an 8-bit transmit value or a control word over a simple register bus. It then sets a self-clearing start bit. The controller then carries out one of three line operations: it sends a byte, it receives a byte, or it drives a long low break and checks whether a slave pulls the line low afterwards (presence). Two timing sets are available. The short-slot set has 70-tick slots and a 480-tick break. The long-slot set has 190-tick bit periods and a 190-tick break. A control bit picks between them.

Bit timing is counted in ticks, and a tick is `DIV` clock cycles. The engine opens every slot by pulling the line low for a length set by the operation and the bit value. It then releases the line. For receive and break operations it samples the line at a fixed tick inside the slot. Data moves least significant bit first. A single-bit option shortens a transfer to one slot, which suits tree-search algorithms. Completion sets one of three flags. Reading the flag register clears all three, and an interrupt line reports them.

Top module: `swire_master`

## Requirements
- R1: After `rst_n` is released, every register reads 0 except revision and status. Status bit0 reads 0 for `RST_CYC` cycles and then 1.
- R2: The revision word (index 0) reads `{REV_MAJ, REV_MIN}` in bits 7:4 and 3:0. The config word (index 5) reads back bit0 (auto-idle) as written.
- R3: Writing control (index 3) with bit4 = 1 and bit1 = 0 sends the transmit byte (index 1) least significant bit first, one slot per bit. The low pulse lasts W1L ticks for a 1 and W0L ticks for a 0, using the set chosen by control bit0 (1 = short-slot, 0 = long-slot).
- R4: At the end of a send, interrupt-status bit2 is set, and control bit4 returns to 0 when control bit6 is 1.
- R5: Control bit4 = 1 with bit1 = 1 receives 8 bits least significant bit first into the receive register (index 2). Each bit is 1 unless a slave holds the line low at the sample tick. Interrupt-status bit1 is set at the end.
- R6: Control bits 2 and 4 set together drive a low break of BRK ticks. At the end, interrupt-status bit0 is set, and control bit3 reads 1 exactly when the line was low PDS ticks after the release. Bits 2 and 4 then clear.
- R7: With control bit7 = 1, a transfer uses one slot only. A send uses transmit bit0. A receive writes the bit into receive bit0 and clears bits 7:1.
- R8: Reading interrupt status (index 4) returns the flags and clears them. A flag set in the same cycle is kept.
- R9: With control bit6 = 0, a transfer still completes and sets its flag, but bit4 stays 1. Bit4 clears once bit6 is written to 1.
- R10: `irq` is high exactly when control bit6 is 1 and any interrupt-status flag is set.
- R11: With control bit5 (clock enable) = 0, a pending start waits and the line stays released. The transfer starts once bit5 is written 1.
- R12: Writing config bit1 = 1 clears all registers and drops status bit0 for `RST_CYC` cycles. Bus writes in that window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| line_in | input | 1 | Sensed level of the data line |
| line_oe | output | 1 | 1 = pull the line low |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures every low pulse to the exact cycle in both timing sets. It decodes bytes whose bit patterns mix 0 and 1. A design that used the wrong pulse length for either bit value, or sent the most significant bit first, would decode to a different byte. A slave model answers reads and presence, so a reversed shift, a sample taken at the wrong tick, or an inverted presence bit would show up in the value read back. The bench also goes after the corners: it checks that a single-bit receive clears the stale upper bits, that a completion with the interrupt mask off holds the start bit set, that a start waits while the clock enable is off, and that writes are ignored during the soft-reset window.

// File: rtl/swire_master.sv
module swire_master #(
  parameter int DIV = 50,
  parameter int RST_CYC = 8,
  parameter int REV_MAJ = 2,
  parameter int REV_MIN = 1,
  parameter int S_SLOT = 70,  parameter int S_W1L = 6,   parameter int S_W0L = 60,
  parameter int S_RDL = 6,    parameter int S_RDS = 15,  parameter int S_BRK = 480,
  parameter int S_PDS = 70,   parameter int S_BRKP = 960,
  parameter int L_SLOT = 190, parameter int L_W1L = 32,  parameter int L_W0L = 145,
  parameter int L_RDL = 32,   parameter int L_RDS = 100, parameter int L_BRK = 190,
  parameter int L_PDS = 40,   parameter int L_BRKP = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_word,
  input  logic [7:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        line_in,
  output logic        line_oe,
  output logic        irq
);
  localparam int TMAX = (S_BRKP > L_BRKP) ? S_BRKP : L_BRKP;
  localparam int CW = $clog2(TMAX + 1);
  localparam int PW = $clog2(DIV + 1);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_BRK = 2'd2;

  typedef enum logic [1:0] {IDLE = 2'd0, RUN = 2'd1, HOLD = 2'd2} st_t;

  st_t st;
  logic [7:0] tx, rx, sh;
  logic single, ie, clken, go, pres, init, dir, mode, autoidle;
  logic [2:0] flags, fset, bidx;
  logic [1:0] kind;
  logic rmode, rsingle, smp;
  logic [CW-1:0] tc, t_low, t_smp, t_per;
  logic [PW-1:0] pc;
  logic [RW-1:0] rcnt;
  logic tick, slot_end, fin, rd_isr, wr_any, wr_ctrl, wr_tx, sreset, done, start;

  always_comb begin
    if (kind == K_BRK) begin
      t_low = rmode ? CW'(S_BRK) : CW'(L_BRK);
      t_smp = rmode ? CW'(S_BRK + S_PDS) : CW'(L_BRK + L_PDS);
      t_per = rmode ? CW'(S_BRKP) : CW'(L_BRKP);
    end else if (kind == K_RD) begin
      t_low = rmode ? CW'(S_RDL) : CW'(L_RDL);
      t_smp = rmode ? CW'(S_RDS) : CW'(L_RDS);
      t_per = rmode ? CW'(S_SLOT) : CW'(L_SLOT);
    end else begin
      t_low = sh[0] ? (rmode ? CW'(S_W1L) : CW'(L_W1L)) : (rmode ? CW'(S_W0L) : CW'(L_W0L));
      t_smp = '0;
      t_per = rmode ? CW'(S_SLOT) : CW'(L_SLOT);
    end
  end

  assign done     = (rcnt == '0);
  assign wr_any   = bus_sel && bus_wr && done;
  assign wr_tx    = wr_any && bus_word == 3'd1;
  assign wr_ctrl  = wr_any && bus_word == 3'd3;
  assign sreset   = wr_any && bus_word == 3'd5 && bus_wdata[1];
  assign rd_isr   = bus_sel && !bus_wr && bus_word == 3'd4;
  assign tick     = (pc == PW'(DIV - 1));
  assign slot_end = (st == RUN) && tick && (tc == t_per - CW'(1));
  assign fin      = slot_end && (kind == K_BRK || rsingle || bidx == 3'd7);
  assign fset     = {fin && kind == K_WR, fin && kind == K_RD, fin && kind == K_BRK};
  assign start    = (st == IDLE) && go && clken;
  assign line_oe  = (st == RUN) && (tc < t_low);
  assign irq      = ie && (|flags);

  always_comb begin
    case (bus_word)
      3'd0:    bus_rdata = {24'd0, 4'(REV_MAJ), 4'(REV_MIN)};
      3'd1:    bus_rdata = {24'd0, tx};
      3'd2:    bus_rdata = {24'd0, rx};
      3'd3:    bus_rdata = {24'd0, single, ie, clken, go, pres, init, dir, mode};
      3'd4:    bus_rdata = {29'd0, flags};
      3'd5:    bus_rdata = {31'd0, autoidle};
      3'd6:    bus_rdata = {31'd0, done};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sreset) begin
      st <= IDLE; tx <= '0; rx <= '0; sh <= '0; flags <= '0; bidx <= '0; kind <= K_WR;
      {single, ie, clken, go, pres, init, dir, mode, autoidle} <= '0;
      rmode <= 1'b0; rsingle <= 1'b0; smp <= 1'b0; tc <= '0; pc <= '0;
      rcnt <= RW'(RST_CYC);
    end else begin
      if (!done) rcnt <= rcnt - RW'(1);
      flags <= (rd_isr ? 3'b000 : flags) | fset;
      if (wr_tx) tx <= bus_wdata;
      if (wr_any && bus_word == 3'd5) autoidle <= bus_wdata[0];
      if (wr_ctrl) begin
        ie <= bus_wdata[6];
        clken <= bus_wdata[5];
        if (st == IDLE) begin
          single <= bus_wdata[7]; go <= bus_wdata[4]; init <= bus_wdata[2];
          dir <= bus_wdata[1]; mode <= bus_wdata[0];
        end
      end
      case (st)
        IDLE: if (start) begin
          st <= RUN; tc <= '0; pc <= '0; bidx <= '0; smp <= 1'b0;
          kind <= init ? K_BRK : (dir ? K_RD : K_WR);
          rmode <= mode; rsingle <= single; sh <= tx;
        end
        RUN: begin
          pc <= tick ? '0 : pc + PW'(1);
          if (tick) begin
            if (kind != K_WR && tc == t_smp) smp <= line_in;
            if (tc == t_per - CW'(1)) begin
              tc <= '0;
              bidx <= bidx + 3'd1;
              sh <= (kind == K_RD) ? {smp, sh[7:1]} : {1'b0, sh[7:1]};
              if (fin) begin
                if (kind == K_RD) rx <= rsingle ? {7'd0, smp} : {smp, sh[7:1]};
                if (kind == K_BRK) pres <= !smp;
                if (ie) begin go <= 1'b0; init <= 1'b0; st <= IDLE; end
                else st <= HOLD;
              end
            end else tc <= tc + CW'(1);
          end
        end
        HOLD: if (ie) begin go <= 1'b0; init <= 1'b0; st <= IDLE; end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module swire_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic [1:0] kind,
  input logic       fin,
  input logic       ie,
  input logic       clken,
  input logic       go,
  input logic       init,
  input logic [2:0] flags,
  input logic       rd_isr,
  input logic       line_oe,
  input logic       sreset,
  input logic       done
);
  p_isr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && !fin && !sreset) |=> (flags == 3'b000));
  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ie && !sreset) |=> (!go && !init));
  p_go_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !ie && !sreset) |=> go);
  p_rx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && kind == 2'd1 && !sreset) |=> flags[1]);
  p_no_clk_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !clken) |=> !line_oe);
  p_sreset_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> !done);
endmodule

bind swire_master swire_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .kind(kind), .fin(fin), .ie(ie), .clken(clken),
  .go(go), .init(init), .flags(flags), .rd_isr(rd_isr), .line_oe(line_oe),
  .sreset(sreset), .done(done)
);

// File: tb/test_swire_master.sv
module test_swire_master;
  localparam int DIV = 2, RST_CYC = 8;
  localparam int S_SLOT = 70, S_W1L = 6, S_W0L = 60, S_RDL = 6, S_RDS = 15, S_BRK = 480, S_PDS = 70, S_BRKP = 960;
  localparam int L_SLOT = 190, L_W1L = 32, L_W0L = 145, L_RDL = 32, L_RDS = 100, L_BRK = 190, L_PDS = 40, L_BRKP = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_word = '0;
  logic [7:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic line_in, line_oe, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  swire_master #(
    .DIV(DIV), .RST_CYC(RST_CYC), .REV_MAJ(2), .REV_MIN(1),
    .S_SLOT(S_SLOT), .S_W1L(S_W1L), .S_W0L(S_W0L), .S_RDL(S_RDL), .S_RDS(S_RDS),
    .S_BRK(S_BRK), .S_PDS(S_PDS), .S_BRKP(S_BRKP),
    .L_SLOT(L_SLOT), .L_W1L(L_W1L), .L_W0L(L_W0L), .L_RDL(L_RDL), .L_RDS(L_RDS),
    .L_BRK(L_BRK), .L_PDS(L_PDS), .L_BRKP(L_BRKP)
  ) i_swire_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .line_oe(line_oe), .irq(irq)
  );

  // slave model and pulse recorder
  logic prev_oe = 1'b0;
  int since = 0, bi = 0, lowcnt = 0, wcount = 0;
  int wl [16];
  logic rd_en = 1'b0, pres_en = 1'b0;
  logic [7:0] rbits = '0;
  int bi0 = 0, rds_t = S_RDS, pds_t = S_BRK + S_PDS;
  logic pull;

  always @(posedge clk) begin
    prev_oe <= line_oe;
    if (line_oe && !prev_oe) begin since <= 0; bi <= bi + 1; end
    else since <= since + 1;
    if (line_oe) lowcnt <= lowcnt + 1;
    else if (prev_oe) begin wl[wcount % 16] <= lowcnt; wcount <= wcount + 1; lowcnt <= 0; end
  end

  always_comb begin
    pull = 1'b0;
    if (rd_en && (bi - bi0) >= 1 && (bi - bi0) <= 8 && !rbits[(bi - bi0 - 1) & 7] && since < (rds_t + 5) * DIV)
      pull = 1'b1;
    if (pres_en && since >= (pds_t - 10) * DIV && since < (pds_t + 10) * DIV)
      pull = 1'b1;
  end
  assign line_in = !line_oe && !pull;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_word = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_word = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic wait_go;
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd3, v);
      if (!v[4]) break;
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic decode(input int wc0, input int n, input int w1, input int w0, output logic [31:0] got);
    got = '0;
    if (wcount - wc0 != n) got = 32'hBAD;
    else for (int k = 0; k < n; k++) begin
      if (wl[(wc0 + k) % 16] == w1 * DIV) got[k] = 1'b1;
      else if (wl[(wc0 + k) % 16] != w0 * DIV) got = 32'hBAD;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, got;
    logic [7:0] pats [4];
    int wc0, m, w1, w0, brk, pds;
    pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd6, v); chk("R1 status busy after reset", v, 32'h0);
    repeat (20) @(negedge clk);
    rd(3'd6, v); chk("R1 status done", v, 32'h1);
    for (int a = 1; a <= 5; a++) begin rd(3'(a), v); chk("R1 register zero after reset", v, 32'h0); end
    rd(3'd0, v); chk("R2 revision", v, 32'h21);
    wr(3'd5, 8'h01); rd(3'd5, v); chk("R2 autoidle readback", v, 32'h1);

    for (int mi = 0; mi < 2; mi++) begin
      m = (mi == 0) ? 1 : 0;
      w1 = m ? S_W1L : L_W1L; w0 = m ? S_W0L : L_W0L;
      brk = m ? S_BRK : L_BRK; pds = m ? S_PDS : L_PDS;
      rds_t = m ? S_RDS : L_RDS; pds_t = brk + pds;

      // break with and without presence
      pres_en = 1'b1; wc0 = wcount;
      wr(3'd3, 8'(8'h74 | m)); wait_go;
      rd(3'd3, v); chk("R6 presence seen, INIT and GO clear", v, 32'(8'h68 | m));
      chk("R6 break low length", 32'(wl[wc0 % 16]), 32'(brk * DIV));
      rd(3'd4, v); chk("R6 timeout flag", v, 32'h1);
      rd(3'd4, v); chk("R8 flags cleared by read", v, 32'h0);
      pres_en = 1'b0;
      wr(3'd3, 8'(8'h74 | m)); wait_go;
      rd(3'd3, v); chk("R6 no presence", v, 32'(8'h60 | m));
      rd(3'd4, v); chk("R6 timeout flag no slave", v, 32'h1);

      // byte sends
      for (int p = 0; p < 4; p++) begin
        wr(3'd1, pats[p]); wc0 = wcount;
        wr(3'd3, 8'(8'h70 | m)); wait_go;
        decode(wc0, 8, w1, w0, got); chk("R3 sent byte decoded from pulse widths", got, 32'(pats[p]));
        chk("R10 irq high with flag", 32'(irq), 32'h1);
        rd(3'd4, v); chk("R4 transmit complete flag", v, 32'h4);
        chk("R10 irq low after clear", 32'(irq), 32'h0);
      end

      // byte receives
      for (int p = 0; p < 4; p++) begin
        rbits = pats[p] ^ 8'h0F; bi0 = bi; rd_en = 1'b1;
        wr(3'd3, 8'(8'h72 | m)); wait_go; rd_en = 1'b0;
        rd(3'd2, v); chk("R5 received byte", v, 32'(pats[p] ^ 8'h0F));
        rd(3'd4, v); chk("R5 receive complete flag", v, 32'h2);
      end

      // single-bit receive and send
      rbits = 8'h00; bi0 = bi; rd_en = 1'b1; wc0 = wcount;
      wr(3'd3, 8'(8'hF2 | m)); wait_go; rd_en = 1'b0;
      rd(3'd2, v); chk("R7 single bit 0, upper bits cleared", v, 32'h0);
      chk("R7 one slot only on receive", 32'(wcount - wc0), 32'h1);
      rbits = 8'h01; bi0 = bi; rd_en = 1'b1;
      wr(3'd3, 8'(8'hF2 | m)); wait_go; rd_en = 1'b0;
      rd(3'd2, v); chk("R7 single bit 1", v, 32'h1);
      wr(3'd1, 8'hFE); wc0 = wcount;
      wr(3'd3, 8'(8'hF0 | m)); wait_go;
      decode(wc0, 1, w1, w0, got); chk("R7 single send uses bit0", got, 32'h0);
      rd(3'd4, v); chk("R7 single flags", v, 32'h6);

      // completion with mask off
      wr(3'd1, 8'h5A);
      wr(3'd3, 8'(8'h30 | m));
      repeat (3400) @(negedge clk);
      rd(3'd3, v); chk("R9 GO held with mask off", v, 32'(8'h30 | m));
      chk("R10 irq masked", 32'(irq), 32'h0);
      wr(3'd3, 8'(8'h60 | m));
      repeat (3) @(negedge clk);
      rd(3'd3, v); chk("R9 GO clears once mask set", v, 32'(8'h60 | m));
      chk("R10 irq after unmask", 32'(irq), 32'h1);
      rd(3'd4, v); chk("R9 flag set while masked", v, 32'h4);

      // clock enable off holds the start
      wc0 = wcount;
      wr(3'd3, 8'(8'h50 | m));
      repeat (300) @(negedge clk);
      chk("R11 no line activity", 32'(wcount - wc0), 32'h0);
      rd(3'd3, v); chk("R11 GO pending", v, 32'(8'h50 | m));
      wr(3'd3, 8'(8'h70 | m)); wait_go;
      decode(wc0, 8, w1, w0, got); chk("R11 starts after enable", got, 32'h5A);
      rd(3'd4, v); chk("R11 flag", v, 32'h4);
    end

    // soft reset
    wr(3'd1, 8'h77);
    wr(3'd5, 8'h02);
    rd(3'd6, v); chk("R12 status low during soft reset", v, 32'h0);
    wr(3'd1, 8'h99);
    repeat (20) @(negedge clk);
    rd(3'd6, v); chk("R12 status done", v, 32'h1);
    rd(3'd1, v); chk("R12 transmit cleared, write ignored", v, 32'h0);
    rd(3'd5, v); chk("R12 config cleared", v, 32'h0);
    rd(3'd3, v); chk("R12 control cleared", v, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule